// File: doc/BRIEF.md
# Sector Erase Queue and Suspend Controller

This block sits behind a flash command decoder and owns the sector erase phase. The decoder hands it single-cycle command pulses. These are a sector erase write that carries a sector index, a suspend request, a resume request, and any other command. The block also receives a per-sector protection mask. The first sector erase write opens a collection window. Each further sector erase write inside that window adds a sector to a bitmap and restarts the window.

When the window runs out, the block drops the protected sectors from the bitmap and erases the rest one at a time, from the lowest index up. Each sector takes a fixed number of cycles on an internal counter. The block reports completion with a one-cycle `done` pulse.

A suspend request behaves differently depending on the phase. During the window it stops collection at once and parks the block. During an erase it takes effect after a fixed latency, while the erase keeps running. A resume restarts the counter from where it stopped. Every time limit is given in microseconds and turned into cycles from a clock-rate parameter, so a bench can shrink the limits.

Top module: `erase_queue_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `erasing`, `suspended`, `tmr_flag`, `done` and `sel_map` are all 0.
- R2: A `cmd_se` pulse while idle sets bit `cmd_sa` of `sel_map` (bit i stands for sector i) and opens the window. In the window `erasing` is 1 and `tmr_flag` is 0.
- R3: Each `cmd_se` pulse inside the window ORs one more bit into `sel_map` and restarts the window. Erasure starts `WIN_CYC` cycles after the most recent such write, where `WIN_CYC = CLK_KHZ*WIN_US/1000`. From then on `tmr_flag` is 1.
- R4: A `cmd_other` pulse inside the window, with no `cmd_se` or `cmd_susp` in the same cycle, cancels the operation. All outputs return to 0 and no `done` pulse follows.
- R5: At erase start the bits set in `prot_mask` are cleared from `sel_map`. The remaining sectors are erased in ascending index order, each for `ERASE_CYC` cycles, and each bit clears when its sector finishes. With n sectors, `done` pulses high for one cycle `WIN_CYC + n*ERASE_CYC + 1` sampled cycles after the final write, and `erasing` and `sel_map` drop to 0 with it.
- R6: If every selected sector is protected, `erasing` stays 1 with an empty `sel_map` for `PROT_CYC` cycles after the window. Then `done` pulses and the block goes idle.
- R7: Once erasure has started, `cmd_se`, `cmd_other` and `cmd_resume` change neither `sel_map` nor the completion time.
- R8: A `cmd_susp` pulse inside the window parks the block in the next cycle, provided at least one selected sector is unprotected. `suspended` becomes 1, `tmr_flag` 1 and `erasing` 0.
- R9: A `cmd_susp` pulse during an erase raises `suspended` exactly `SUSP_CYC` cycles later, and the erase counter keeps running meanwhile. If the final sector completes no later than that cycle, completion wins: `done` pulses and `suspended` never rises.
- R10: While suspended, the erase counter is frozen and `sel_map` holds. `cmd_se`, `cmd_other` and `cmd_susp` are ignored. After `cmd_resume` the erase continues from the held position, so completion is delayed by exactly the number of suspended cycles.
- R11: While `prog_busy` is 1, a `cmd_susp` pulse during an erase is ignored.
- R12: `cmd_resume` outside the suspended state has no effect. Inside the window it neither cancels nor restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_se | input | 1 | Sector erase write pulse |
| cmd_sa | input | $clog2(NSEC) | Sector index carried by `cmd_se` |
| cmd_susp | input | 1 | Erase suspend pulse |
| cmd_resume | input | 1 | Erase resume pulse |
| cmd_other | input | 1 | Any other decoded command |
| prog_busy | input | 1 | A program or chip erase runs elsewhere; blocks suspend |
| prot_mask | input | NSEC | Per-sector protection, 1 = protected |
| erasing | output | 1 | Busy: window open, erase running or protected wait |
| suspended | output | 1 | Erase parked |
| sel_map | output | NSEC | Sectors selected and not yet erased |
| tmr_flag | output | 1 | 0 while more sectors may be added, 1 once erasure has begun |
| done | output | 1 | One-cycle pulse when the erase phase ends |

## Verification
The sharp corner is a pending suspend whose latency expires in the same cycle that the last selected sector finishes erasing. The bench provokes it by placing the suspend write exactly `SUSP_CYC` cycles before the computed completion. It also places the write one cycle earlier and a few cycles later. For the coinciding and later writes it expects `done` at the unchanged completion cycle and no cycle with `suspended` high. For the earlier write it expects a real suspend, and after resume a completion delayed by exactly the counted suspended cycles. A second overlap is a new sector write landing in the same cycle the window would expire; the window must restart rather than launch, which the random runs check through the total completion time.

// File: rtl/erq_pkg.sv
package erq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_RUN,
    ST_HOLDREQ,
    ST_SUSP,
    ST_PROT
  } erq_state_e;

  // Microseconds to clock cycles, never below one cycle.
  function automatic int unsigned us_to_cyc(int unsigned khz, int unsigned us);
    int unsigned c;
    c = (khz * us) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/erq_tick.sv
module erq_tick #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign hit = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run)   cnt <= hit ? '0 : cnt + 1'b1;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT - 1));

  // R10
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/erq_lowbit.sv
module erq_lowbit #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] oh
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    assign oh[gi] = vec[gi] && ((vec & ((N'(1) << gi) - N'(1))) == '0);
  end
endmodule

// File: rtl/erq_engine.sv
module erq_engine #(
  parameter int          NSEC      = 8,
  parameter int unsigned ERASE_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            run,
  input  logic [NSEC-1:0] map,
  output logic [NSEC-1:0] fin_oh
);
  logic            sec_hit;
  logic [NSEC-1:0] low_oh;

  erq_tick #(.LIMIT(ERASE_CYC)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .run (run),
    .hit (sec_hit)
  );

  erq_lowbit #(.N(NSEC)) u_low (
    .vec (map),
    .oh  (low_oh)
  );

  assign fin_oh = sec_hit ? low_oh : '0;

  // R5
  fin_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fin_oh));

  // R5
  fin_in_map_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_oh & ~map) == '0);

endmodule

// File: rtl/erase_queue_ctrl.sv
module erase_queue_ctrl
  import erq_pkg::*;
#(
  parameter int          NSEC      = 11,
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned WIN_US    = 50,
  parameter int unsigned SUSP_US   = 20,
  parameter int unsigned PROT_US   = 100,
  parameter int unsigned ERASE_CYC = 100000,
  localparam int         SAW       = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_se,
  input  logic [SAW-1:0]  cmd_sa,
  input  logic            cmd_susp,
  input  logic            cmd_resume,
  input  logic            cmd_other,
  input  logic            prog_busy,
  input  logic [NSEC-1:0] prot_mask,
  output logic            erasing,
  output logic            suspended,
  output logic [NSEC-1:0] sel_map,
  output logic            tmr_flag,
  output logic            done
);
  localparam int unsigned WIN_CYC  = us_to_cyc(CLK_KHZ, WIN_US);
  localparam int unsigned SUSP_CYC = us_to_cyc(CLK_KHZ, SUSP_US);
  localparam int unsigned PROT_CYC = us_to_cyc(CLK_KHZ, PROT_US);

  erq_state_e      state_q, nxt;
  logic [NSEC-1:0] sel_q, sel_d, sa_oh, keep, remain, fin_oh;
  logic            done_d, erasing_q, susp_q, tmr_q, done_q;
  logic            win_hit, lat_hit, prot_hit;
  logic            in_win, se_take, launch_now, cancel, lat_clr, last;

  for (genvar gi = 0; gi < NSEC; gi++) begin : g_sa
    assign sa_oh[gi] = (cmd_sa == SAW'(gi));
  end

  assign in_win     = (state_q == ST_WIN);
  assign se_take    = cmd_se && ((state_q == ST_IDLE) || (in_win && !cmd_susp));
  assign launch_now = in_win && (cmd_susp || (!cmd_se && !cmd_other && win_hit));
  assign cancel     = in_win && !cmd_susp && !cmd_se && cmd_other;
  assign keep       = sel_q & ~prot_mask;
  assign lat_clr    = (state_q == ST_RUN) && cmd_susp && !prog_busy;
  assign remain     = sel_q & ~fin_oh;
  assign last       = (fin_oh != '0) && (remain == '0);

  erq_tick #(.LIMIT(WIN_CYC)) u_win (
    .clk (clk), .rst (rst), .clr (se_take), .run (in_win), .hit (win_hit)
  );

  erq_tick #(.LIMIT(SUSP_CYC)) u_lat (
    .clk (clk), .rst (rst), .clr (lat_clr),
    .run (state_q == ST_HOLDREQ), .hit (lat_hit)
  );

  erq_tick #(.LIMIT(PROT_CYC)) u_prot (
    .clk (clk), .rst (rst), .clr (launch_now),
    .run (state_q == ST_PROT), .hit (prot_hit)
  );

  erq_engine #(.NSEC(NSEC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk    (clk),
    .rst    (rst),
    .start  (launch_now),
    .run    ((state_q == ST_RUN) || (state_q == ST_HOLDREQ)),
    .map    (sel_q),
    .fin_oh (fin_oh)
  );

  always_comb begin
    nxt    = state_q;
    sel_d  = sel_q;
    done_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_se) begin
          nxt   = ST_WIN;
          sel_d = sa_oh;
        end
      end
      ST_WIN: begin
        if (launch_now) begin
          sel_d = keep;
          if (keep == '0)    nxt = ST_PROT;
          else if (cmd_susp) nxt = ST_SUSP;
          else               nxt = ST_RUN;
        end else if (se_take) begin
          sel_d = sel_q | sa_oh;
        end else if (cancel) begin
          sel_d = '0;
          nxt   = ST_IDLE;
        end
      end
      ST_RUN, ST_HOLDREQ: begin
        sel_d = remain;
        if (last) begin
          nxt    = ST_IDLE;
          done_d = 1'b1;
        end else if (lat_clr) begin
          nxt = ST_HOLDREQ;
        end else if ((state_q == ST_HOLDREQ) && lat_hit) begin
          nxt = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (cmd_resume) nxt = ST_RUN;
      end
      ST_PROT: begin
        if (prot_hit) begin
          nxt    = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      erasing_q <= 1'b0;
      susp_q    <= 1'b0;
      tmr_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= nxt;
      sel_q     <= sel_d;
      erasing_q <= (nxt == ST_WIN) || (nxt == ST_RUN) ||
                   (nxt == ST_HOLDREQ) || (nxt == ST_PROT);
      susp_q    <= (nxt == ST_SUSP);
      tmr_q     <= (nxt != ST_IDLE) && (nxt != ST_WIN);
      done_q    <= done_d;
    end
  end

  assign erasing   = erasing_q;
  assign suspended = susp_q;
  assign sel_map   = sel_q;
  assign tmr_flag  = tmr_q;
  assign done      = done_q;

  // R10
  park_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (susp_q && !cmd_resume) |=> (susp_q && $stable(sel_q)));

  // R7
  no_add_chk: assert property (@(posedge clk) disable iff (rst)
    (tmr_q && $past(tmr_q)) |-> ((sel_q & ~$past(sel_q)) == '0));

  // R5
  prot_skip_chk: assert property (@(posedge clk) disable iff (rst)
    launch_now |=> ((sel_q & $past(prot_mask)) == '0));

  // R4
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(tmr_q));

  // R8
  win_park_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && cmd_susp && (keep != '0)) |=> susp_q);

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RUN) && prog_busy) |=> (state_q != ST_HOLDREQ));

endmodule

// File: tb/sim_erase_queue_ctrl.sv
module sim_erase_queue_ctrl;
  localparam int NS = 11;
  localparam int W  = 50;
  localparam int S  = 20;
  localparam int P  = 100;
  localparam int E  = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_se = 1'b0, cmd_susp = 1'b0, cmd_resume = 1'b0, cmd_other = 1'b0;
  logic          prog_busy = 1'b0;
  logic [3:0]    cmd_sa = '0;
  logic [NS-1:0] prot_mask = '0;
  logic          erasing, suspended, tmr_flag, done;
  logic [NS-1:0] sel_map;

  int total = 0, bad = 0;
  int t = 0, scnt = 0, dcnt = 0;

  always #10 clk = ~clk;

  erase_queue_ctrl #(
    .NSEC(NS), .CLK_KHZ(1000), .WIN_US(50), .SUSP_US(20),
    .PROT_US(100), .ERASE_CYC(E)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_se(cmd_se), .cmd_sa(cmd_sa),
    .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_other(cmd_other),
    .prog_busy(prog_busy), .prot_mask(prot_mask), .erasing(erasing),
    .suspended(suspended), .sel_map(sel_map), .tmr_flag(tmr_flag), .done(done)
  );

  function automatic int popc(logic [NS-1:0] v);
    int n = 0;
    for (int i = 0; i < NS; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int exp_time(logic [NS-1:0] sel, logic [NS-1:0] prot);
    int n = popc(sel & ~prot);
    return W + 1 + ((n == 0) ? P : n * E);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    t++;
    if (suspended) scnt++;
    if (done) dcnt++;
  endtask

  task automatic stepto(int n);
    while (t < n) tick();
  endtask

  task automatic fresh();
    t = 0; scnt = 0; dcnt = 0;
  endtask

  task automatic se(int idx, bit restart);
    cmd_se = 1'b1; cmd_sa = 4'(idx);
    tick();
    cmd_se = 1'b0;
    if (restart) t = 1;
  endtask

  task automatic pz(int which);
    case (which)
      0: cmd_susp = 1'b1;
      1: cmd_resume = 1'b1;
      default: cmd_other = 1'b1;
    endcase
    tick();
    cmd_susp = 1'b0; cmd_resume = 1'b0; cmd_other = 1'b0;
  endtask

  task automatic wait_done(int lim);
    while (!done && t < lim) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp, t0;
    logic [NS-1:0] acc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!erasing && !suspended && !tmr_flag && !done && sel_map == '0, "R1", int'(sel_map), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!erasing && !suspended && !tmr_flag && !done, "R1 after release", int'(erasing), 0);

    // R2 R3 R5: two sectors, ascending order
    fresh(); se(2, 1);
    chk(sel_map == 11'h004 && erasing && !tmr_flag, "R2", int'(sel_map), 4);
    repeat (5) tick();
    se(5, 1);
    chk(sel_map == 11'h024, "R3 add", int'(sel_map), 'h24);
    stepto(W);     chk(!tmr_flag, "R3 window open", int'(tmr_flag), 0);
    stepto(W + 1); chk(tmr_flag && sel_map == 11'h024, "R3 window closed", int'(tmr_flag), 1);
    stepto(W + E + 1); chk(sel_map == 11'h020, "R5 lowest first", int'(sel_map), 'h20);
    stepto(W + 2*E);   chk(!done, "R5 early", int'(done), 0);
    stepto(W + 2*E + 1);
    chk(done && !erasing && sel_map == '0, "R5 finish", int'(done), 1);
    tick(); chk(!done, "R5 pulse", int'(done), 0);

    // R4 cancel in window
    fresh(); se(3, 1); stepto(10); pz(2);
    chk(!erasing && !tmr_flag && sel_map == '0, "R4", int'(sel_map), 0);
    dcnt = 0; stepto(200);
    chk(dcnt == 0, "R4 no done", dcnt, 0);

    // R6 all protected
    prot_mask = '1;
    fresh(); se(1, 1); se(7, 1);
    stepto(W + 1); chk(erasing && sel_map == '0, "R6 busy", int'(sel_map), 0);
    wait_done(W + P + 20);
    chk(done && t == W + P + 1, "R6 timing", t, W + P + 1);
    prot_mask = '0; tick();

    // R12 resume in window, R7 commands during erase
    fresh(); se(0, 1); stepto(20); pz(1);
    chk(sel_map == 11'h001 && erasing && !tmr_flag, "R12 resume in window", int'(sel_map), 1);
    stepto(W + 5); se(4, 0); pz(2); pz(1);
    chk(sel_map == 11'h001 && erasing, "R7 ignored", int'(sel_map), 1);
    wait_done(W + E + 20);
    chk(done && t == W + E + 1, "R7 timing", t, W + E + 1);
    tick();

    // R8 R10 suspend in window, frozen while parked
    fresh(); se(6, 1); stepto(10); t0 = t; pz(0);
    chk(suspended && tmr_flag && !erasing, "R8", int'(suspended), 1);
    stepto(70); pz(2); se(3, 0); pz(0);
    chk(suspended && sel_map == 11'h040, "R10 ignored while parked", int'(sel_map), 'h40);
    stepto(90); pz(1); pz(1);
    wait_done(400);
    exp = t0 + scnt + E + 1;
    chk(done && t == exp, "R10 resume continues", t, exp);
    tick();

    // R9 latency during erase
    fresh(); se(1, 1); stepto(W + 10); t0 = t; pz(0);
    stepto(t0 + S); chk(!suspended, "R9 latency early", int'(suspended), 0);
    stepto(t0 + S + 1); chk(suspended && sel_map == 11'h002, "R9 latency", int'(suspended), 1);
    stepto(t0 + S + 30); pz(1);
    wait_done(500);
    exp = W + E + scnt + 1;
    chk(done && t == exp, "R10 total time", t, exp);
    tick();

    // R9 completion coinciding with suspend latency, and later
    for (int k = 0; k < 2; k++) begin
      fresh(); se(8, 1); stepto(W + E - S + 5*k); pz(0);
      wait_done(W + E + 40);
      chk(done && t == W + E + 1 && scnt == 0, "R9 completion wins", t, W + E + 1);
      tick();
    end

    // R9 one cycle earlier: real suspend
    fresh(); se(9, 1); stepto(W + E - S - 1); pz(0);
    stepto(W + E + 5); chk(suspended, "R9 boundary suspend", int'(suspended), 1);
    pz(1); wait_done(400);
    exp = W + E + scnt + 1;
    chk(done && t == exp, "R9 boundary resume", t, exp);
    tick();

    // R11 suspend blocked by prog_busy
    prog_busy = 1'b1;
    fresh(); se(10, 1); stepto(W + 5); pz(0);
    stepto(W + 5 + S + 3); chk(!suspended, "R11", int'(suspended), 0);
    wait_done(W + E + 20);
    chk(done && t == W + E + 1, "R11 timing", t, W + E + 1);
    prog_busy = 1'b0; tick();

    // R3 R5 R6 random collections
    for (int it = 0; it < 16; it++) begin
      int n;
      prot_mask = NS'($urandom) & NS'($urandom);
      acc = '0; fresh();
      n = 1 + int'($urandom % 4);
      for (int j = 0; j < n; j++) begin
        int idx;
        if (j > 0) stepto(t + 1 + int'($urandom % (W - 3)));
        idx = int'($urandom % NS);
        se(idx, 1);
        acc |= NS'(1) << idx;
      end
      chk(sel_map == acc, "R3 random set", int'(sel_map), int'(acc));
      stepto(W + 1);
      chk(sel_map == (acc & ~prot_mask), "R5 random protect", int'(sel_map), int'(acc & ~prot_mask));
      exp = exp_time(acc, prot_mask);
      wait_done(exp + 10);
      chk(done && t == exp, "R5 R6 random timing", t, exp);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule